// File: doc/BRIEF.md
# Register-Stack Integer Arithmetic Unit

This block holds eight signed 32-bit words in a circular register stack. A moving top pointer selects the entry seen as st(0), and every other entry is named by its distance n from that top. Commands arrive one at a time over a valid/ready handshake. A load pushes a word so that it becomes the new st(0). A store returns st(0) and can pop it. The arithmetic commands add, subtract, reverse-subtract or multiply st(0) with st(n). The result can go back into st(0) or into st(n), and the top can then be popped.

Each entry carries a tag bit that marks it as occupied. A push into an occupied slot reports overflow. A command that reads an empty slot reports underflow. In both cases the command leaves the stack exactly as it found it. Every accepted command produces one registered response on the cycle after it is accepted: a data word and two error flags.

Top module: `regstack_alu`

## Requirements
- R1: After reset every slot is empty, `cmd_ready` is low during reset and high from the first clock after it, and `rsp_valid` is low until a command is accepted.
- R2: A load (`cmd_op`=0) writes `cmd_data` into slot (top+7) mod 8, marks the slot occupied and moves top there, so the word becomes st(0). The response echoes the word.
- R3: A load whose target slot is already occupied raises `rsp_overflow`, returns data 0 and changes neither the slots nor the top.
- R4: A store or arithmetic command that reads an empty slot raises `rsp_underflow`, returns data 0 and changes neither the slots nor the top.
- R5: With `cmd_dest_n`=0, an arithmetic command writes st(0) op st(n) into st(0). Physical slot = (top+n) mod 8. The opcodes are 2 add, 3 subtract and 5 multiply.
- R6: With `cmd_dest_n`=1, an arithmetic command writes st(n) op st(0) into st(n).
- R7: Reverse subtract (`cmd_op`=4) swaps the two sources, so it writes the second source minus the first.
- R8: Multiply keeps the low 32 bits of the product, and all arithmetic wraps modulo 2^32.
- R9: With `cmd_pop`=1 an arithmetic command first writes its result and then empties st(0) and moves top up by one. A pop-add into st(1) therefore leaves the sum at the new top.
- R10: A store (`cmd_op`=1) returns st(0). It empties st(0) and moves top up by one when `cmd_pop`=1, and changes nothing when `cmd_pop`=0.
- R11: Opcodes 6 and 7 change no state and respond with data 0 and both flags clear.
- R12: `rsp_valid` is high exactly on the cycle after each accepted command and low otherwise. Each response carries the result or the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode: 0 load, 1 store, 2 add, 3 sub, 4 reverse sub, 5 mul |
| cmd_idx | input | 3 | Relative index n of the second operand |
| cmd_dest_n | input | 1 | 0: result goes to st(0); 1: result goes to st(n) |
| cmd_pop | input | 1 | Pop st(0) after the command |
| cmd_data | input | 32 | Word to push on a load |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 32 | Result, stored word or loaded word; 0 on error |
| rsp_overflow | output | 1 | Push into an occupied slot |
| rsp_underflow | output | 1 | Read of an empty slot |

## Verification
Two functions can land on the same slot in one cycle. The first is the arithmetic write-back, which writes st(n) or st(0). The second is the pop, which clears the tag of st(0). Both act on one slot when the result is sent to st(n) with n=0 and a pop is requested. The bench provokes this case, and also the neighbouring case n=1, where the write and the clear hit different slots. It judges both by draining the stack with stores and comparing every returned word, and every underflow flag, against its reference model. Stack full and stack empty are reached by filling all eight slots and by popping past the bottom.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_SUBR  = 3'd4,
    OP_MUL   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } rs_op_e;

  function automatic logic is_arith(input rs_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SUBR) || (op == OP_MUL);
  endfunction
endpackage

// File: rtl/rs_ptr.sv
module rs_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_push,
  input  logic             do_pop,
  input  logic [IDX_W-1:0] rel_idx,
  output logic [IDX_W-1:0] top_o,
  output logic [IDX_W-1:0] phys_n_o,
  output logic [IDX_W-1:0] phys_push_o
);
  logic [IDX_W-1:0] top_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       top_q <= '0;
    else if (do_push) top_q <= top_q - IDX_W'(1);
    else if (do_pop)  top_q <= top_q + IDX_W'(1);
  end

  assign top_o       = top_q;
  assign phys_n_o    = top_q + rel_idx;
  assign phys_push_o = top_q - IDX_W'(1);

  // R9: a command never pushes and pops together
  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_push && do_pop));
  // R2: a push moves the top down by one slot
  p_push_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> top_q == $past(top_q) - IDX_W'(1));
  // R9: a pop moves the top up by one slot
  p_pop_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> top_q == $past(top_q) + IDX_W'(1));
endmodule

// File: rtl/rs_slot_file.sv
module rs_slot_file #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_addr,
  input  logic [IDX_W-1:0]  rd_addr_a,
  input  logic [IDX_W-1:0]  rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DEPTH-1:0]  tags_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  tag_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_wr, hit_clr;
    assign hit_wr  = wr_en  && (wr_addr  == IDX_W'(i));
    assign hit_clr = clr_en && (clr_addr == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
        tag_q[i]  <= 1'b0;
      end else begin
        if (hit_wr) slot_q[i] <= wr_data;
        if (hit_clr)     tag_q[i] <= 1'b0;
        else if (hit_wr) tag_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data_a = slot_q[rd_addr_a];
  assign rd_data_b = slot_q[rd_addr_b];
  assign tags_o    = tag_q;

  // R9: the controller never writes and clears the same slot in one cycle
  p_wr_clr_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en && (wr_addr == clr_addr)));
  // R2: a written slot is occupied afterwards
  p_write_tags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(clr_en && clr_addr == wr_addr)) |=> tag_q[$past(wr_addr)]);
endmodule

// File: rtl/rs_alu.sv
module rs_alu #(
  parameter int DATA_W = 32
) (
  input  rs_pkg::rs_op_e     op,
  input  logic               dest_n,
  input  logic [DATA_W-1:0]  st_top,
  input  logic [DATA_W-1:0]  st_rel,
  output logic [DATA_W-1:0]  result
);
  import rs_pkg::*;

  function automatic logic [DATA_W-1:0] calc(input rs_op_e o,
                                             input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] r;
    case (o)
      OP_ADD:  r = x + y;
      OP_SUB:  r = x - y;
      OP_SUBR: r = y - x;
      OP_MUL:  r = x * y;
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] first_src, second_src;
  assign first_src  = dest_n ? st_rel : st_top;
  assign second_src = dest_n ? st_top : st_rel;
  assign result     = calc(op, first_src, second_src);
endmodule

// File: rtl/regstack_alu.sv
module regstack_alu #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              cmd_dest_n,
  input  logic              cmd_pop,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_overflow,
  output logic              rsp_underflow
);
  import rs_pkg::*;

  rs_op_e            op;
  logic              acc;
  logic [IDX_W-1:0]  top, phys_n, phys_push, dest;
  logic [DEPTH-1:0]  tags;
  logic [DATA_W-1:0] st_top, st_rel, alu_res;
  logic              do_push, do_pop, wr_en, clr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data, res_data;
  logic              ovf_ev, unf_ev;
  logic              ready_q, rsp_valid_q, ovf_q, unf_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign op  = rs_op_e'(cmd_op);
  assign acc = cmd_valid && ready_q;

  rs_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .do_push(do_push), .do_pop(do_pop),
    .rel_idx(cmd_idx), .top_o(top), .phys_n_o(phys_n), .phys_push_o(phys_push)
  );

  rs_slot_file #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_en(clr_en), .clr_addr(top),
    .rd_addr_a(top), .rd_addr_b(phys_n),
    .rd_data_a(st_top), .rd_data_b(st_rel), .tags_o(tags)
  );

  rs_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .dest_n(cmd_dest_n), .st_top(st_top), .st_rel(st_rel), .result(alu_res)
  );

  assign dest = cmd_dest_n ? phys_n : top;

  always_comb begin
    do_push  = 1'b0;
    do_pop   = 1'b0;
    wr_en    = 1'b0;
    clr_en   = 1'b0;
    wr_addr  = phys_push;
    wr_data  = cmd_data;
    res_data = '0;
    ovf_ev   = 1'b0;
    unf_ev   = 1'b0;
    if (acc) begin
      if (op == OP_LOAD) begin
        if (tags[phys_push]) ovf_ev = 1'b1;
        else begin
          wr_en    = 1'b1;
          do_push  = 1'b1;
          res_data = cmd_data;
        end
      end else if (op == OP_STORE) begin
        if (!tags[top]) unf_ev = 1'b1;
        else begin
          res_data = st_top;
          clr_en   = cmd_pop;
          do_pop   = cmd_pop;
        end
      end else if (is_arith(op)) begin
        if (!(tags[top] && tags[phys_n])) unf_ev = 1'b1;
        else begin
          res_data = alu_res;
          wr_addr  = dest;
          wr_data  = alu_res;
          wr_en    = !(cmd_pop && dest == top);
          clr_en   = cmd_pop;
          do_pop   = cmd_pop;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      ovf_q       <= 1'b0;
      unf_q       <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= acc;
      rsp_data_q  <= acc ? res_data : '0;
      ovf_q       <= ovf_ev;
      unf_q       <= unf_ev;
    end
  end

  assign cmd_ready     = ready_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign rsp_overflow  = ovf_q;
  assign rsp_underflow = unf_q;

  // R12: one response on the cycle after each accepted command
  p_resp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  // R12: no response without an accepted command
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  // R3: a push into an occupied slot flags overflow and leaves state alone
  p_overflow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_LOAD && tags[phys_push]) |=>
      (rsp_overflow && tags == $past(tags) && top == $past(top)));
  // R4: reading an empty slot flags underflow and leaves state alone
  p_underflow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_arith(op) && !(tags[top] && tags[phys_n])) |=>
      (rsp_underflow && tags == $past(tags) && top == $past(top)));
  // R11: reserved opcodes touch nothing and respond clean
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_RSV6 || op == OP_RSV7)) |=>
      (!rsp_overflow && !rsp_underflow && rsp_data == '0 && top == $past(top)));
  // R3/R4: an error response never carries data
  p_err_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_overflow || rsp_underflow) |-> (rsp_valid && rsp_data == '0));
endmodule

// File: tb/regstack_alu_test.sv
module regstack_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic        cmd_dest_n = 1'b0;
  logic        cmd_pop = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_overflow, rsp_underflow;

  int n_checks = 0;
  int n_fail = 0;

  // reference model: plain integers, indexed by physical slot
  int mval [8];
  bit mtag [8];
  int mtop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regstack_alu uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_dest_n(cmd_dest_n), .cmd_pop(cmd_pop),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_overflow(rsp_overflow), .rsp_underflow(rsp_underflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input int op, input int n, input bit dn, input bit pp,
                       input int d, input string req);
    int e_data = 0;
    bit e_ovf = 0, e_unf = 0;
    int t = mtop;
    int pn = (mtop + n) % 8;
    int pu = (mtop + 7) % 8;
    case (op)
      0: if (mtag[pu]) e_ovf = 1;
         else begin mval[pu] = d; mtag[pu] = 1; mtop = pu; e_data = d; end
      1: if (!mtag[t]) e_unf = 1;
         else begin
           e_data = mval[t];
           if (pp) begin mtag[t] = 0; mtop = (t + 1) % 8; end
         end
      2, 3, 4, 5: if (!(mtag[t] && mtag[pn])) e_unf = 1;
         else begin
           int x = dn ? mval[pn] : mval[t];
           int y = dn ? mval[t] : mval[pn];
           int r;
           if (op == 2) r = x + y;
           else if (op == 3) r = x - y;
           else if (op == 4) r = y - x;
           else r = x * y;
           mval[dn ? pn : t] = r;
           e_data = r;
           if (pp) begin mtag[t] = 0; mtop = (t + 1) % 8; end
         end
      default: ;
    endcase
    cmd_valid = 1; cmd_op = 3'(op); cmd_idx = 3'(n);
    cmd_dest_n = dn; cmd_pop = pp; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    check(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
    check(rsp_data == 32'(e_data), req, "rsp_data", rsp_data, 32'(e_data));
    check(rsp_overflow == e_ovf, req, "overflow", rsp_overflow, e_ovf);
    check(rsp_underflow == e_unf, req, "underflow", rsp_underflow, e_unf);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12", "idle rsp_valid", rsp_valid, 0);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 9; k++) issue(1, 0, 0, 1, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mval[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b0, "R1", "ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

    issue(1, 0, 0, 0, 0, "R1");           // empty stack store -> underflow
    issue(2, 1, 0, 0, 0, "R4");
    idle_cycle();

    issue(0, 0, 0, 0, 10, "R2");
    issue(0, 0, 0, 0, 3, "R2");
    issue(2, 1, 0, 0, 0, "R5");           // st0 = 3+10
    issue(1, 0, 0, 0, 0, "R10");          // no pop
    issue(3, 1, 1, 0, 0, "R6");           // st1 = 10-13
    issue(4, 1, 0, 0, 0, "R7");           // st0 = st1 - st0
    issue(4, 1, 1, 0, 0, "R7");           // st1 = st0 - st1
    issue(3, 2, 0, 0, 0, "R4");           // st2 empty
    idle_cycle();
    issue(0, 0, 0, 0, 32'h0001_0001, "R2");
    issue(0, 0, 0, 0, 32'h7fff_0003, "R2");
    issue(5, 1, 0, 0, 0, "R8");
    issue(5, 2, 1, 0, 0, "R8");
    issue(2, 1, 1, 1, 0, "R9");           // pop-add into st1
    issue(1, 0, 0, 0, 0, "R9");
    issue(3, 0, 1, 1, 0, "R9");           // write and pop on same slot
    issue(6, 2, 1, 1, 5, "R11");
    issue(7, 0, 0, 1, 5, "R11");
    issue(1, 0, 0, 0, 0, "R11");
    drain("R10");

    for (int k = 0; k < 8; k++) issue(0, 0, 0, 0, 100 + k, "R2");
    issue(0, 0, 0, 0, 999, "R3");
    issue(2, 7, 0, 0, 0, "R5");
    issue(2, 7, 1, 1, 0, "R9");
    issue(0, 0, 0, 0, -5, "R2");
    issue(0, 0, 0, 0, 7, "R3");
    issue(3, 5, 0, 1, 0, "R9");
    issue(1, 0, 0, 1, 0, "R10");
    idle_cycle();
    issue(2, 3, 1, 0, 0, "R6");
    drain("R10");
    idle_cycle();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule